// File: doc/BRIEF.md
# Multi-Channel Compare-Match Event Timer

This block is an event timer on a 32-bit register bus. A single free-running main counter is shared by three compare channels. Each channel watches the counter and raises its own interrupt line when the counter equals the channel's match value. A channel can be one-shot, firing once per programmed match value, or periodic, rearming itself by adding a stored period to its match value after every hit.

Software reads the capability words to learn the channel count and the tick period. It sets the run bit to start the counter and then programs each channel through a configuration word and a compare word. A channel's interrupt either pulses for one clock or is held on a bit in a shared status word, which software clears by writing one to that bit. Only channel 0 supports periodic operation. A periodic channel is armed with two compare writes: the first gives the time of the first hit and the second gives the period.

Register word addresses: 0 capability, 1 tick period in femtoseconds, 2 global control (bit 0 = run), 3 interrupt status, 4 main counter, 8+2c channel c configuration, 9+2c channel c compare. Unmapped addresses read 0. Channel configuration bits: 0 interrupt enable, 1 level mode, 2 periodic, 3 periodic-capable (read-only), 4 arm-sequence start (write-only, reads 0), 5 narrow-compare (stored; with the 32-bit counter the comparison is full width).

Top module: `et_event_timer`

## Requirements
- R1: After reset the counter reads 0 and is stopped, the status word reads 0, every compare word reads 0xFFFFFFFF, the configuration of channel 0 reads 0x08 and of the other channels 0x00, and all irq lines are low.
- R2: Word 0 reads the channel count minus one in bits 7:0 (value 2) and bit 8 = 0 to indicate a 32-bit counter. Word 1 reads the tick period in femtoseconds (20000000 by default).
- R3: While bit 0 of word 2 is 1, the counter advances by one each clock. While it is 0, the counter holds its value.
- R4: A write to word 4 loads the counter only while the counter is stopped. While the counter runs, such a write is ignored.
- R5: A one-shot channel fires in the clock cycle in which the running counter equals its compare value. It does not fire again until its compare word is rewritten.
- R6: On channel 0, writing configuration bit 4 as 1 starts the arm sequence. The next compare write sets the match time and the write after it sets the period. Bit 4 always reads 0. On channels 1 and 2, bits 2 and 4 have no effect and bit 2 reads 0, so every compare write sets the match time.
- R7: On a periodic channel, every match raises the interrupt and adds the stored period to the match value that word 9+2c reads back.
- R8: In level mode with the interrupt enabled, a match sets status bit c one clock after the matching cycle. irq_o[c] follows that bit until software writes 1 to it in word 3.
- R9: In edge mode with the interrupt enabled, irq_o[c] is high for exactly one clock after a match, and status bit c stays 0.
- R10: With interrupt enable at 0, a match, a compare write, or both leave irq_o[c] and status bit c at 0.
- R11: No match is taken while the counter is stopped, even when the counter equals the compare value. The match is taken at the first running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the addressed register |
| irq_o | output | N_CH | One interrupt line per channel |

## Verification
The hardest case to reach is a match that lands on a known cycle: the counter is always moving, so a compare value written while it runs lands at a time that depends on bus latency. The stimulus stops the counter, reads its value, writes that exact value as a compare, checks that nothing fires while the counter is stopped, and then restarts it. For the periodic channel, the arm sequence is issued while the counter runs, with the first hit placed far enough ahead that it cannot be missed. Each hit is then cleared within the period, so every status rise is seen separately and the final compare value can be checked against the first hit plus the hit count times the period.

// File: rtl/et_pkg.sv
package et_pkg;
  // register word addresses
  localparam int ADR_CAPS    = 0;
  localparam int ADR_TICK    = 1;
  localparam int ADR_GCTL    = 2;
  localparam int ADR_ISTAT   = 3;
  localparam int ADR_COUNT   = 4;
  localparam int ADR_CH_BASE = 8;
  localparam int CH_STRIDE   = 2;

  // channel configuration bit positions
  localparam int CB_IEN  = 0;
  localparam int CB_LVL  = 1;
  localparam int CB_PER  = 2;
  localparam int CB_CAP  = 3;
  localparam int CB_VSET = 4;
  localparam int CB_M32  = 5;

  typedef enum logic [1:0] {
    VS_IDLE = 2'd0,
    VS_ACC  = 2'd1,
    VS_PER  = 2'd2
  } vs_state_e;
endpackage

// File: rtl/et_main_counter.sv
module et_main_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_wr,
  input  logic             run_wdata,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (run_wr) run_d = run_wdata;
    if (run_q)       cnt_d = cnt_q + CNT_W'(1);
    else if (cnt_wr) cnt_d = cnt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr) |=> $stable(cnt_q));
  p_cnt_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && cnt_wr) |=> cnt_q == $past(cnt_wdata));
endmodule

// File: rtl/et_status.sv
module et_status #(
  parameter int N_CH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] set_i,
  input  logic            clr_wr,
  input  logic [N_CH-1:0] clr_mask,
  output logic [N_CH-1:0] stat_o
);
  logic [N_CH-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_wr) stat_d = stat_d & ~clr_mask;
    stat_d = stat_d | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_mask[c] && !set_i[c]) |=> !stat_q[c]);
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[c] && !(clr_wr && clr_mask[c])) |=> stat_q[c]);
  end
endmodule

// File: rtl/et_channel.sv
module et_channel
  import et_pkg::*;
#(
  parameter int   DATA_W  = 32,
  parameter logic PER_CAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cmp_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              run_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] cfg_rd_o,
  output logic [DATA_W-1:0] tgt_o,
  output logic              lvl_o,
  output logic              stat_set_o,
  output logic              pulse_o
);
  localparam int LOW_W = (DATA_W < 32) ? DATA_W : 32;

  logic              ien_q, ien_d, lvl_q, lvl_d, per_q, per_d, m32_q, m32_d;
  vs_state_e         vs_q, vs_d;
  logic [DATA_W-1:0] tgt_q, tgt_d, prd_q, prd_d;
  logic              armed_q, armed_d, pulse_q, pulse_d;
  logic              hit, fire;

  always_comb begin
    if (m32_q) hit = (cnt_i[LOW_W-1:0] == tgt_q[LOW_W-1:0]);
    else       hit = (cnt_i == tgt_q);
    fire = run_i && armed_q && hit;
  end

  always_comb begin
    ien_d   = ien_q;
    lvl_d   = lvl_q;
    per_d   = per_q;
    m32_d   = m32_q;
    vs_d    = vs_q;
    tgt_d   = tgt_q;
    prd_d   = prd_q;
    armed_d = armed_q;
    // match effects first; bus writes below take precedence
    if (fire) begin
      if (per_q) tgt_d   = tgt_q + prd_q;
      else       armed_d = 1'b0;
    end
    if (cfg_wr) begin
      ien_d = wdata[CB_IEN];
      lvl_d = wdata[CB_LVL];
      m32_d = wdata[CB_M32];
      per_d = PER_CAP & wdata[CB_PER];
      vs_d  = (PER_CAP && wdata[CB_VSET]) ? VS_ACC : VS_IDLE;
    end
    if (cmp_wr) begin
      unique case (vs_q)
        VS_ACC: begin
          tgt_d   = wdata;
          armed_d = 1'b1;
          vs_d    = VS_PER;
        end
        VS_PER: begin
          prd_d = wdata;
          vs_d  = VS_IDLE;
        end
        default: begin
          tgt_d   = wdata;
          armed_d = 1'b1;
        end
      endcase
    end
    pulse_d = fire && ien_q && !lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= 1'b0;
      lvl_q   <= 1'b0;
      per_q   <= 1'b0;
      m32_q   <= 1'b0;
      vs_q    <= VS_IDLE;
      tgt_q   <= '1;
      prd_q   <= '0;
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ien_q   <= ien_d;
      lvl_q   <= lvl_d;
      per_q   <= per_d;
      m32_q   <= m32_d;
      vs_q    <= vs_d;
      tgt_q   <= tgt_d;
      prd_q   <= prd_d;
      armed_q <= armed_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    cfg_rd_o         = '0;
    cfg_rd_o[CB_IEN] = ien_q;
    cfg_rd_o[CB_LVL] = lvl_q;
    cfg_rd_o[CB_PER] = per_q;
    cfg_rd_o[CB_CAP] = PER_CAP;
    cfg_rd_o[CB_M32] = m32_q;
  end

  assign tgt_o      = tgt_q;
  assign lvl_o      = lvl_q;
  assign stat_set_o = fire && ien_q && lvl_q;
  assign pulse_o    = pulse_q;

  p_oneshot_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !per_q && !cmp_wr) |=> !armed_q);
  p_period_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && per_q && !(cmp_wr && vs_q != VS_PER)) |=> tgt_q == $past(tgt_q + prd_q));
  p_vset_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr && vs_q == VS_PER) |=> (vs_q == VS_IDLE && prd_q == $past(wdata)));
  p_stopped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !cmp_wr && !cfg_wr) |=> ($stable(tgt_q) && !pulse_q));
endmodule

// File: rtl/et_event_timer.sv
module et_event_timer
  import et_pkg::*;
#(
  parameter int          N_CH         = 3,
  parameter int          DATA_W       = 32,
  parameter int          ADDR_W       = 6,
  parameter int unsigned TICK_FS      = 20000000,
  parameter int unsigned PER_CAP_MASK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   irq_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic wr;
  assign wr = bus_en && bus_we;

  logic              run;
  logic [DATA_W-1:0] cnt;

  et_main_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .run_wr    (wr && int'(bus_addr) == ADR_GCTL),
    .run_wdata (bus_wdata[0]),
    .cnt_wr    (wr && int'(bus_addr) == ADR_COUNT),
    .cnt_wdata (bus_wdata),
    .run_o     (run),
    .cnt_o     (cnt)
  );

  logic [DATA_W-1:0] cfg_rd [N_CH];
  logic [DATA_W-1:0] tgt    [N_CH];
  logic [N_CH-1:0]   lvl, set_req, pulse, stat;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int A_CFG = ADR_CH_BASE + CH_STRIDE * c;
    et_channel #(
      .DATA_W  (DATA_W),
      .PER_CAP (((PER_CAP_MASK >> c) & 1) != 0)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .cfg_wr     (wr && int'(bus_addr) == A_CFG),
      .cmp_wr     (wr && int'(bus_addr) == A_CFG + 1),
      .wdata      (bus_wdata),
      .run_i      (run),
      .cnt_i      (cnt),
      .cfg_rd_o   (cfg_rd[c]),
      .tgt_o      (tgt[c]),
      .lvl_o      (lvl[c]),
      .stat_set_o (set_req[c]),
      .pulse_o    (pulse[c])
    );
    assign irq_o[c] = lvl[c] ? stat[c] : pulse[c];

    p_stat_needs_ien_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
      $rose(stat[c]) |-> $past(cfg_rd[c][CB_IEN]));
    p_edge_no_status_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
      $rose(stat[c]) |-> $past(cfg_rd[c][CB_LVL]));
    p_pulse_needs_ien_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
      $rose(pulse[c]) |-> $past(cfg_rd[c][CB_IEN]));
  end

  et_status #(.N_CH(N_CH)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .set_i    (set_req),
    .clr_wr   (wr && int'(bus_addr) == ADR_ISTAT),
    .clr_mask (bus_wdata[N_CH-1:0]),
    .stat_o   (stat)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (int'(bus_addr))
      ADR_CAPS:  bus_rdata[7:0] = 8'(N_CH - 1);
      ADR_TICK:  bus_rdata = DATA_W'(TICK_FS);
      ADR_GCTL:  bus_rdata[0] = run;
      ADR_ISTAT: bus_rdata[N_CH-1:0] = stat;
      ADR_COUNT: bus_rdata = cnt;
      default: begin
        for (int c = 0; c < N_CH; c++) begin
          if (int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * c)     bus_rdata = cfg_rd[c];
          if (int'(bus_addr) == ADR_CH_BASE + CH_STRIDE * c + 1) bus_rdata = tgt[c];
        end
      end
    endcase
  end
endmodule

// File: tb/sim_et_event_timer.sv
module sim_et_event_timer;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_o;

  et_event_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] mc;
  bit          mrun;
  logic [31:0] mt [N];
  logic [31:0] mp [N];
  bit ma [N], mien [N], mlvl [N], mper [N], mm32 [N], mst [N], mpl [N];
  int mvs [N];

  task automatic m_reset();
    mc = 0; mrun = 0;
    for (int c = 0; c < N; c++) begin
      mt[c] = '1; mp[c] = 0; ma[c] = 0; mien[c] = 0; mlvl[c] = 0;
      mper[c] = 0; mm32[c] = 0; mst[c] = 0; mpl[c] = 0; mvs[c] = 0;
    end
  endtask

  initial m_reset();

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] d = 0;
    if (a == 0) d = N - 1;
    else if (a == 1) d = 32'd20000000;
    else if (a == 2) d = {31'd0, mrun};
    else if (a == 3) begin for (int c = 0; c < N; c++) d[c] = mst[c]; end
    else if (a == 4) d = mc;
    else for (int c = 0; c < N; c++) begin
      if (a == 8 + 2*c) d = {26'd0, mm32[c], 1'b0, (c == 0), mper[c], mlvl[c], mien[c]};
      if (a == 9 + 2*c) d = mt[c];
    end
    return d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_reset();
    else begin
      bit f [N];
      bit wr;
      int a;
      wr = bus_en && bus_we;
      a  = int'(bus_addr);
      for (int c = 0; c < N; c++) f[c] = mrun && ma[c] && (mc == mt[c]);
      for (int c = 0; c < N; c++) begin
        mpl[c] = f[c] && mien[c] && !mlvl[c];
        if (wr && a == 3 && bus_wdata[c]) mst[c] = 0;
        if (f[c] && mien[c] && mlvl[c]) mst[c] = 1;
        if (f[c]) begin
          if (mper[c]) mt[c] = mt[c] + mp[c];
          else ma[c] = 0;
        end
        if (wr && a == 8 + 2*c) begin
          mien[c] = bus_wdata[0]; mlvl[c] = bus_wdata[1]; mm32[c] = bus_wdata[5];
          mper[c] = (c == 0) && bus_wdata[2];
          mvs[c]  = ((c == 0) && bus_wdata[4]) ? 1 : 0;
        end
        if (wr && a == 9 + 2*c) begin
          if (mvs[c] == 1)      begin mt[c] = bus_wdata; ma[c] = 1; mvs[c] = 2; end
          else if (mvs[c] == 2) begin mp[c] = bus_wdata; mvs[c] = 0; end
          else                  begin mt[c] = bus_wdata; ma[c] = 1; end
        end
      end
      if (mrun) mc = mc + 1;
      else if (wr && a == 4) mc = bus_wdata;
      if (wr && a == 2) mrun = bus_wdata[0];
    end
  end

  // every-clock comparison of the interrupt lines, plus event monitors
  int pulses2 = 0;
  int rises0  = 0;
  logic prev0 = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < N; c++) begin
        bit exp_i;
        exp_i = mlvl[c] ? mst[c] : mpl[c];
        chk(irq_o[c] === exp_i, mlvl[c] ? "R8 irq vs model" : "R9 irq vs model",
            32'(irq_o[c]), 32'(exp_i));
      end
      if (irq_o[2]) pulses2++;
      if (irq_o[0] && !prev0) rises0++;
      prev0 = irq_o[0];
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = 6'(a);
    #1;
    d = bus_rdata;
    chk(d === m_read(a), "R3 read vs model", d, m_read(a));
    bus_en = 0;
  endtask

  task automatic wait_irq(input int c, input string tag);
    int k = 0;
    while (!irq_o[c] && k < 300) begin @(negedge clk); k++; end
    chk(irq_o[c] === 1'b1, tag, 32'(irq_o[c]), 32'd1);
  endtask

  // ---------------- directed sequence ----------------
  task automatic run_test();
    logic [31:0] d, v, acc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1, R2 reset and capability
    rd(0, d);  chk(d == 32'd2, "R2 caps", d, 32'd2);
    rd(1, d);  chk(d == 32'd20000000, "R2 tick", d, 32'd20000000);
    rd(2, d);  chk(d == 0, "R1 run", d, 0);
    rd(4, d);  chk(d == 0, "R1 count", d, 0);
    rd(3, d);  chk(d == 0, "R1 status", d, 0);
    rd(8, d);  chk(d == 32'h08, "R1 cfg0", d, 32'h08);
    rd(10, d); chk(d == 0, "R1 cfg1", d, 0);
    rd(13, d); chk(d == 32'hFFFFFFFF, "R1 cmp2", d, 32'hFFFFFFFF);
    chk(irq_o == 0, "R1 irq", 32'(irq_o), 0);

    // R4 load while stopped, R3 hold
    wr(4, 32'd1000);
    rd(4, d); chk(d == 32'd1000, "R4 load", d, 32'd1000);
    repeat (5) @(negedge clk);
    rd(4, d); chk(d == 32'd1000, "R3 hold", d, 32'd1000);

    // R5, R8 one-shot level on channel 1
    wr(10, 32'h3);
    wr(11, 32'd1010);
    wr(2, 32'd1);
    wait_irq(1, "R8 level fire");
    rd(3, d); chk(d == 32'h2, "R8 status set", d, 32'h2);
    repeat (4) @(negedge clk);
    chk(irq_o[1] === 1'b1, "R8 held", 32'(irq_o[1]), 1);
    wr(3, 32'h2);
    rd(3, d); chk(d == 0, "R8 w1c", d, 0);
    repeat (20) @(negedge clk);
    rd(3, d); chk(d == 0, "R5 no refire", d, 0);

    // R4 write ignored while running
    wr(4, 32'd5);
    rd(4, d); chk(d > 32'd1000, "R4 ignored while running", d, 32'd1001);

    // R9 edge mode on channel 2
    pulses2 = 0;
    wr(12, 32'h1);
    wr(13, mc + 32'd10);
    repeat (20) @(negedge clk);
    chk(pulses2 == 1, "R9 single pulse", 32'(pulses2), 1);
    rd(3, d); chk(d == 0, "R9 no status", d, 0);

    // R10 disabled channel
    pulses2 = 0;
    wr(12, 32'h2);
    wr(13, mc + 32'd6);
    repeat (12) @(negedge clk);
    rd(3, d); chk(d == 0, "R10 no status", d, 0);
    chk(irq_o[2] === 1'b0, "R10 irq low", 32'(irq_o[2]), 0);

    // R6, R7 periodic arm on channel 0
    wr(8, 32'h17);
    rd(8, d); chk(d == 32'h0F, "R6 cfg0 readback", d, 32'h0F);
    acc = mc + 32'd30;
    wr(9, acc);
    wr(9, 32'd15);
    rd(9, d); chk(d == acc, "R6 accumulator", d, acc);
    rises0 = 0;
    for (int k = 0; k < 4; k++) begin
      wait_irq(0, "R7 periodic fire");
      wr(3, 32'h1);
    end
    chk(rises0 == 4, "R7 fire count", 32'(rises0), 4);
    rd(9, d); chk(d == acc + 32'(15 * rises0), "R7 advance", d, acc + 32'(15 * rises0));
    wr(8, 32'h0);

    // R6 non-capable channel
    wr(10, 32'h14);
    rd(10, d); chk(d == 0, "R6 cfg1 no periodic", d, 0);
    wr(11, 32'h00AB0000);
    wr(11, 32'h00CD0000);
    rd(11, d); chk(d == 32'h00CD0000, "R6 cmp1 direct", d, 32'h00CD0000);

    // R11 no match while stopped
    wr(10, 32'h3);
    wr(2, 32'd0);
    rd(4, v);
    wr(11, v);
    repeat (6) @(negedge clk);
    rd(3, d); chk(d == 0, "R11 stopped no fire", d, 0);
    wr(2, 32'd1);
    repeat (3) @(negedge clk);
    rd(3, d); chk(d == 32'h2, "R11 fire on restart", d, 32'h2);
    wr(3, 32'h2);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit timeout = 0;
    fork
      run_test();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule